// File: doc/BRIEF.md
# Indirect Register Access over a Scan Data Register

This block lets a test host read and write internal registers through one JTAG data-register path without giving each register its own scan chain. The host first loads the target register's address through the instruction register; that address reaches the block on `ir_addr`. It then shifts a 20-bit command through the data register. Bits 19:18 carry an operation code and bits 17:0 carry write data. The block turns each command into one transaction on a simple internal register bus.

Commands may be shorter than 20 bits. A read needs only its two operation bits. A status check needs only one bit out, because a capture always puts the busy flag in the first position shifted out. The command is shifted least significant bit first, so the operation code is always taken from the two bits shifted in most recently. After starting a read or a write, the host polls busy until it clears. It then collects read data with a further capture and shift.

Top module: `jtag_indirect_port`

## Requirements
- R1: After reset, busy, `bus_re`, `bus_we` and `tdo` are all 0.
- R2: On a capture, the scan register loads busy into bit 0, the last completed read data into bits 18:1 and 0 into bit 19. Bits leave on `tdo` from bit 0 upward, one per shift. The busy value captured is the one held before that clock edge.
- R3: An update whose operation code is 00 or 01 starts nothing. An update after fewer than two shifts since the last capture also starts nothing.
- R4: An update after at least two shifts, with operation code 10 and busy low, starts a read. The last bit shifted is code bit 1 and the bit before it is code bit 0. The read raises `bus_re` and `bus_addr` holds the value `ir_addr` had at the update.
- R5: An update with operation code 11, after at least 20 shifts and with busy low, starts a write. It raises `bus_we`, and `bus_wdata` holds bits 17:0 of the command (the first 18 bits shifted). Code 11 after fewer than 20 shifts starts nothing.
- R6: Busy rises in the cycle after a starting update. The request, address and write data then hold steady until `bus_ready` is sampled high. Busy and the request fall in the cycle after that.
- R7: A read's completion stores `bus_rdata` for the next capture. A write's completion leaves the stored read data unchanged.
- R8: A read or write command that updates while busy is high is dropped, even in the cycle in which the pending transaction completes. No second request follows.
- R9: `bus_re` and `bus_we` are never high together.
- R10: Changes on `ir_addr` after the starting update do not reach `bus_addr` while the transaction is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the scan path and the register bus |
| rst_n | input | 1 | Active-low reset |
| ir_addr | input | AW | Register address loaded through the instruction register |
| capture_dr | input | 1 | Capture strobe for this data register |
| shift_dr | input | 1 | Shift strobe for this data register |
| update_dr | input | 1 | Update strobe for this data register |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (bit 0 of the scan register) |
| bus_addr | output | AW | Register bus address |
| bus_wdata | output | DW | Register bus write data |
| bus_we | output | 1 | Write request, held until ready |
| bus_re | output | 1 | Read request, held until ready |
| bus_rdata | input | DW | Register bus read data, valid with ready |
| bus_ready | input | 1 | Completion of the pending request |
| busy | output | 1 | A transaction is pending |

## Verification
Two kinds of collision are forced. In the first, an update carrying a new write lands in the same cycle as the pending read's `bus_ready`. The bench drives the update and the ready on the same negative edge. It expects busy to drop, no write request to appear, and the read data to be kept. In the second, a capture lands in the completion cycle. Here the first bit out must still read busy as 1, and a later capture must show the new data. Around these two cases, the bench sweeps several addresses and data words through write and read cycles with varied bus latency. It also covers one-bit commands, truncated writes and commands sent while busy, and computes every expected word arithmetically.

// File: rtl/jtag_indirect_port.sv
module jtag_indirect_port #(
  parameter int AW = 8,
  parameter int DW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ir_addr,
  input  logic          capture_dr,
  input  logic          shift_dr,
  input  logic          update_dr,
  input  logic          tdi,
  output logic          tdo,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  output logic          bus_we,
  output logic          bus_re,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_ready,
  output logic          busy
);
  localparam int CW = DW + 2;
  localparam int NW = $clog2(CW + 1);

  logic [CW-1:0] sr;
  logic [NW-1:0] nbits;
  logic [DW-1:0] rd_q;
  logic          rd_pend, wr_pend;

  wire [1:0] op    = sr[CW-1:CW-2];
  wire       go_rd = update_dr && !busy && (nbits >= NW'(2)) && (op == 2'b10);
  wire       go_wr = update_dr && !busy && (nbits == NW'(CW)) && (op == 2'b11);

  assign busy   = rd_pend | wr_pend;
  assign bus_re = rd_pend;
  assign bus_we = wr_pend;
  assign tdo    = sr[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr    <= '0;
      nbits <= '0;
    end else if (capture_dr) begin
      sr    <= {1'b0, rd_q, busy};
      nbits <= '0;
    end else if (shift_dr) begin
      sr <= {tdi, sr[CW-1:1]};
      if (nbits != NW'(CW)) nbits <= nbits + NW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pend   <= 1'b0;
      wr_pend   <= 1'b0;
      rd_q      <= '0;
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else if (busy) begin
      if (bus_ready) begin
        if (rd_pend) rd_q <= bus_rdata;
        rd_pend <= 1'b0;
        wr_pend <= 1'b0;
      end
    end else if (go_rd) begin
      rd_pend  <= 1'b1;
      bus_addr <= ir_addr;
    end else if (go_wr) begin
      wr_pend   <= 1'b1;
      bus_addr  <= ir_addr;
      bus_wdata <= sr[DW-1:0];
    end
  end

  assert_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_re && bus_we));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !bus_ready |=> busy && $stable(bus_addr) && $stable(bus_wdata)
                           && $stable(bus_re));

  assert_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy && bus_ready |=> !busy);

  assert_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(update_dr));

  assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    capture_dr |=> tdo == $past(busy));

  assert_nosecond_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && bus_ready |=> !bus_re && !bus_we);
endmodule

// File: tb/jtag_indirect_port_tb.sv
module jtag_indirect_port_tb;
  localparam int AW = 8;
  localparam int DW = 18;

  logic          clk = 0;
  logic          rst_n = 0;
  logic [AW-1:0] ir_addr = '0;
  logic          capture_dr = 0, shift_dr = 0, update_dr = 0, tdi = 0;
  logic          tdo;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic          bus_we, bus_re;
  logic [DW-1:0] bus_rdata = '0;
  logic          bus_ready = 0;
  logic          busy;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  jtag_indirect_port #(.AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .ir_addr(ir_addr),
    .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
    .tdi(tdi), .tdo(tdo), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .busy(busy)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic capture();
    capture_dr = 1; @(negedge clk); capture_dr = 0;
  endtask

  task automatic update();
    update_dr = 1; @(negedge clk); update_dr = 0;
  endtask

  task automatic shift_in(input int n, input logic [19:0] v, output logic [19:0] outv);
    outv = '0;
    for (int i = 0; i < n; i++) begin
      shift_dr = 1; tdi = v[i]; outv[i] = tdo;
      @(negedge clk);
    end
    shift_dr = 0; tdi = 0;
  endtask

  task automatic serve(input int lat, input logic [DW-1:0] rd);
    for (int g = 0; g < 100 && !(bus_re || bus_we); g++) @(negedge clk);
    repeat (lat) @(negedge clk);
    bus_rdata = rd; bus_ready = 1;
    @(negedge clk);
    bus_ready = 0;
  endtask

  task automatic readback(input string tag, input logic [DW-1:0] exp);
    logic [19:0] o;
    capture();
    shift_in(19, 20'h0, o);
    check({tag, " busy bit"}, o[0], 1'b0);
    check({tag, " data"}, o[18:1], exp);
    update();
    check("R3 poll after readback starts nothing", {bus_re, bus_we}, 2'b00);
  endtask

  function automatic logic [DW-1:0] wval(input int a);
    return DW'(a * 9973 + 1);
  endfunction

  function automatic logic [DW-1:0] rval(input int a);
    return DW'(a * 4099 + 12345);
  endfunction

  initial begin
    logic [19:0] o;
    logic [AW-1:0] a;
    repeat (2) @(negedge clk);
    check("R1 busy", busy, 0);
    check("R1 requests", {bus_re, bus_we}, 0);
    check("R1 tdo", tdo, 0);
    rst_n = 1;
    @(negedge clk);

    for (int k = 0; k < 8; k++) begin
      a = AW'(k * 37 + 3);
      ir_addr = a;
      capture();
      shift_in(20, {2'b11, wval(k)}, o);
      update();
      ir_addr = ~a;
      check("R5 write request", bus_we, 1);
      check("R9 no read with write", bus_re, 0);
      check("R6 busy after update", busy, 1);
      check("R5 write data", bus_wdata, wval(k));
      @(negedge clk);
      check("R10 address held", bus_addr, a);
      serve(k % 3, DW'(18'h3FFFF));
      check("R6 busy cleared", busy, 0);
      check("R6 write dropped", bus_we, 0);

      ir_addr = a;
      capture();
      shift_in(2, 20'h2, o);
      update();
      ir_addr = ~a;
      check("R4 read request", bus_re, 1);
      check("R4 read address", bus_addr, a);
      serve((k + 1) % 4, rval(k));
      check("R6 read done", {busy, bus_re}, 0);
      readback("R7 readback", rval(k));
    end

    // one-bit command while idle would look like a read without the length gate
    capture();
    shift_in(1, 20'h1, o);
    check("R2 idle busy first out", o[0], 0);
    update();
    check("R3 one-bit update", {busy, bus_re, bus_we}, 0);

    capture();
    shift_in(10, 20'h300, o);
    update();
    check("R5 short write ignored", {busy, bus_we}, 0);

    capture();
    shift_in(20, {2'b01, 18'h2AAAA}, o);
    update();
    check("R3 code 01 ignored", {busy, bus_re, bus_we}, 0);

    ir_addr = 8'h5A;
    capture();
    shift_in(2, 20'h2, o);
    update();
    capture();
    shift_in(1, 20'h0, o);
    check("R2 busy seen while pending", o[0], 1);
    ir_addr = 8'h11;
    capture();
    shift_in(20, {2'b11, 18'h12345}, o);
    update();
    check("R8 write while busy dropped", bus_we, 0);
    check("R8 address unchanged", bus_addr, 8'h5A);
    serve(0, 18'h0BEEF);
    @(negedge clk);
    check("R8 no second request", {busy, bus_re, bus_we}, 0);
    readback("R7 read after dropped write", 18'h0BEEF);

    ir_addr = 8'h22;
    capture();
    shift_in(2, 20'h2, o);
    update();
    capture();
    shift_in(20, {2'b11, 18'h00777}, o);
    update_dr = 1; bus_ready = 1; bus_rdata = 18'h1C3A5;
    @(negedge clk);
    update_dr = 0; bus_ready = 0;
    check("R8 coincident update dropped", {busy, bus_we, bus_re}, 0);
    @(negedge clk);
    check("R8 still idle", {busy, bus_we}, 0);
    readback("R7 coincident read data", 18'h1C3A5);

    capture();
    shift_in(20, {2'b11, 18'h00042}, o);
    update();
    check("R5 write started", bus_wdata, 18'h00042);
    serve(1, 18'h3FFFF);
    readback("R7 write keeps read data", 18'h1C3A5);

    capture();
    shift_in(2, 20'h2, o);
    update();
    capture_dr = 1; bus_ready = 1; bus_rdata = 18'h2468A;
    @(negedge clk);
    capture_dr = 0; bus_ready = 0;
    check("R2 captured busy is pre-edge", tdo, 1);
    check("R6 completion beside capture", busy, 0);
    readback("R7 data after coincident capture", 18'h2468A);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule